// File: doc/BRIEF.md
# UART Host Register Bank with Interrupt Identification

This block is the processor-facing side of a classic single-byte UART. It offers eight byte-wide registers at a 3-bit offset and keeps the configuration, status and interrupt state that serializer logic and driver software share. Offsets 0 and 1 normally carry transmit/receive data and the interrupt enables. While the top bit of the line control register is set, those two offsets reach the two bytes of a 16-bit baud divisor instead.

On the serial side, a receiver hands over a byte with a one-cycle valid strobe, or reports a break condition. A transmitter gets each written byte with a one-cycle strobe. A single interrupt line and an 8-bit identification code come from a fixed priority. Received data comes before transmit-holding-empty, and the transmit source is tracked by a hidden pending flag. Reading the identification register consumes that flag, and rewriting the enables re-arms it. A loopback mode feeds the modem control bits back into the modem status byte.

Bus accesses take one cycle (`bus_sel` high for one clock). Read data is combinational during the access, and any side effects of the read take place at the closing clock edge.

Top module: `uart_regbank`

## Requirements
- R1: Offsets decode as 0 data, 1 interrupt enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch. Line control and scratch read back the full byte last written.
- R2: With line control bit 7 set, offset 0 writes and reads the divisor low byte and offset 1 the high byte, and no transmit happens. The divisor is also driven on `divisor`.
- R3: The interrupt enable register keeps only bits 3:0, and the modem control register keeps only bits 4:0. The other bits read as zero.
- R4: The identification code is 0x04 when data-ready is set and enable bit 0 is set. Otherwise it is 0x02 when the transmit pending flag is set and enable bit 1 is set. Otherwise it is 0x01. `irq` is high exactly when the code differs from 0x01.
- R5: A read of offset 2 that returns 0x02 clears the transmit pending flag. A read that returns any other code leaves the flag unchanged.
- R6: A write to the enable register while line status bit 5 is set sets the transmit pending flag.
- R7: A data write with bit 7 of line control clear pulses `tx_strobe` for the next cycle, presents the byte on `tx_byte`, and sets the pending flag. Line status bits 5 and 6 stay set.
- R8: A data read returns the received byte and clears line status bits 0 (data ready) and 4 (break).
- R9: With modem control bit 4 set, a modem status read returns control bits 3:2 on bits 7:6, control bit 0 on bit 5 and control bit 1 on bit 4, with all other bits zero. With bit 4 clear it reads 0xB0.
- R10: After reset, line status reads 0x60, identification reads 0x01, modem status reads 0xB0, all other registers read 0x00, `irq` is low and `rx_ready` is high.
- R11: A received byte is taken only while data ready is clear, and `rx_ready` is the inverse of data ready. A byte offered while data ready is set is dropped.
- R12: A break strobe loads 0x00 into the receive register and sets line status bits 0 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is selected |
| rx_byte | input | 8 | Byte from the receiver |
| rx_valid | input | 1 | One-cycle strobe for `rx_byte` |
| rx_break | input | 1 | One-cycle break condition strobe |
| rx_ready | output | 1 | High while the receive register is free |
| tx_byte | output | 8 | Byte last written for transmission |
| tx_strobe | output | 1 | One-cycle pulse for a new transmit byte |
| irq | output | 1 | Interrupt request, active high |
| irq_code | output | 8 | Current identification code |
| line_ctl | output | 8 | Line control register contents |
| divisor | output | 16 | Baud divisor |
| modem_ctl | output | 5 | Modem control register contents |

## Verification
The assertions check the following on every cycle:
- the identification code stays within its three legal values and agrees with `irq`;
- received data wins over the transmit source;
- each accepted data write produces exactly one transmit pulse carrying the written byte;
- a blocked receive or a break leaves the receive register in the required state;
- reading a 0x02 code clears the pending flag, and an enable write re-arms it.

The bench scenarios are needed for behaviour that spans several accesses. These are the divisor aliasing and its readback, the masking of the enable and modem control registers, the loopback bit mapping, and the reset contents of every register. They also cover the ordering in which a data read, a dropped byte and a break interact with the identification code.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int REG_W  = 8;
  localparam int OFS_W  = 3;
  localparam int NREG   = 1 << OFS_W;
  localparam int IEN_W  = 4;
  localparam int MCTL_W = 5;
  localparam int DIV_W  = 2 * REG_W;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } reg_ofs_e;

  localparam logic [REG_W-1:0] ID_NONE   = 8'h01;
  localparam logic [REG_W-1:0] ID_TXE    = 8'h02;
  localparam logic [REG_W-1:0] ID_RXD    = 8'h04;
  localparam logic [REG_W-1:0] MSTAT_IDLE = 8'hB0;

  localparam int LC_DIVSEL = 7;
  localparam int MC_LOOP   = 4;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic             sel,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic             div_mode,
  output logic [NREG-1:0]  wr_hit,
  output logic [NREG-1:0]  rd_hit,
  output logic [1:0]       div_wr
);
  logic [NREG-1:0] hit;
  logic [NREG-1:0] div_mask;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (ofs == i[OFS_W-1:0]);
  end

  // offsets 0 and 1 are redirected to the divisor while div_mode is set
  assign div_mask = div_mode ? NREG'(3) : '0;

  assign wr_hit = {NREG{sel & wr}}  & hit & ~div_mask;
  assign rd_hit = {NREG{sel & ~wr}} & hit & ~div_mask;
  assign div_wr = {2{sel & wr & div_mode}} & hit[1:0];
endmodule

// File: rtl/uart_rb_intid.sv
module uart_rb_intid
  import uart_rb_pkg::*;
(
  input  logic             data_rdy,
  input  logic             rx_en,
  input  logic             tx_pend,
  input  logic             tx_en,
  output logic [REG_W-1:0] code,
  output logic             req
);
  always_comb begin
    if (data_rdy && rx_en)      code = ID_RXD;
    else if (tx_pend && tx_en)  code = ID_TXE;
    else                        code = ID_NONE;
  end

  assign req = (code != ID_NONE);
endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
  import uart_rb_pkg::*;
(
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              div_mode,
  input  logic [REG_W-1:0]  rbr,
  input  logic [DIV_W-1:0]  div,
  input  logic [IEN_W-1:0]  ien,
  input  logic [REG_W-1:0]  code,
  input  logic [REG_W-1:0]  lctl,
  input  logic [MCTL_W-1:0] mctl,
  input  logic [REG_W-1:0]  lstat,
  input  logic [REG_W-1:0]  scr,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] mstat;
  logic [REG_W-1:0] sel_data;

  // loopback maps the modem outputs onto the status inputs
  assign mstat = mctl[MC_LOOP] ? {mctl[3], mctl[2], mctl[0], mctl[1], 4'b0000}
                               : MSTAT_IDLE;

  always_comb begin
    unique case (reg_ofs_e'(ofs))
      OFS_DATA:  sel_data = div_mode ? div[REG_W-1:0] : rbr;
      OFS_IEN:   sel_data = div_mode ? div[DIV_W-1:REG_W]
                                     : {{(REG_W-IEN_W){1'b0}}, ien};
      OFS_IID:   sel_data = code;
      OFS_LCTL:  sel_data = lctl;
      OFS_MCTL:  sel_data = {{(REG_W-MCTL_W){1'b0}}, mctl};
      OFS_LSTAT: sel_data = lstat;
      OFS_MSTAT: sel_data = mstat;
      OFS_SCR:   sel_data = scr;
      default:   sel_data = '0;
    endcase
  end

  assign rdata = rd_en ? sel_data : '0;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  rx_byte,
  input  logic              rx_valid,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic [REG_W-1:0]  tx_byte,
  output logic              tx_strobe,
  output logic              irq,
  output logic [REG_W-1:0]  irq_code,
  output logic [REG_W-1:0]  line_ctl,
  output logic [DIV_W-1:0]  divisor,
  output logic [MCTL_W-1:0] modem_ctl
);
  // register state
  logic [REG_W-1:0]  rbr_q, rbr_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic [IEN_W-1:0]  ier_q, ier_n;
  logic [REG_W-1:0]  lcr_q, lcr_n;
  logic [MCTL_W-1:0] mcr_q, mcr_n;
  logic [REG_W-1:0]  scr_q, scr_n;
  logic [REG_W-1:0]  txb_q, txb_n;
  logic              txs_q, txs_n;
  logic              dr_q, dr_n;
  logic              bi_q, bi_n;
  logic              thre_q, thre_n;
  logic              temt_q, temt_n;
  logic              thr_pend_q, thr_pend_n;

  logic [NREG-1:0]   wr_hit, rd_hit;
  logic [1:0]        div_wr;
  logic [REG_W-1:0]  code;
  logic              req;
  logic [REG_W-1:0]  lstat;

  assign lstat = {1'b0, temt_q, thre_q, bi_q, 3'b000, dr_q};

  uart_rb_decode u_dec (
    .sel      (bus_sel),
    .wr       (bus_wr),
    .ofs      (bus_addr),
    .div_mode (lcr_q[LC_DIVSEL]),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit),
    .div_wr   (div_wr)
  );

  uart_rb_intid u_iid (
    .data_rdy (dr_q),
    .rx_en    (ier_q[0]),
    .tx_pend  (thr_pend_q),
    .tx_en    (ier_q[1]),
    .code     (code),
    .req      (req)
  );

  uart_rb_rdmux u_rd (
    .rd_en    (bus_sel & ~bus_wr),
    .ofs      (bus_addr),
    .div_mode (lcr_q[LC_DIVSEL]),
    .rbr      (rbr_q),
    .div      (div_q),
    .ien      (ier_q),
    .code     (code),
    .lctl     (lcr_q),
    .mctl     (mcr_q),
    .lstat    (lstat),
    .scr      (scr_q),
    .rdata    (bus_rdata)
  );

  // next-state logic
  always_comb begin
    rbr_n      = rbr_q;
    div_n      = div_q;
    ier_n      = ier_q;
    lcr_n      = lcr_q;
    mcr_n      = mcr_q;
    scr_n      = scr_q;
    txb_n      = txb_q;
    dr_n       = dr_q;
    bi_n       = bi_q;
    thre_n     = thre_q;
    temt_n     = temt_q;
    thr_pend_n = thr_pend_q;
    txs_n      = wr_hit[OFS_DATA];

    if (div_wr[0]) div_n[REG_W-1:0]     = bus_wdata;
    if (div_wr[1]) div_n[DIV_W-1:REG_W] = bus_wdata;

    if (wr_hit[OFS_LCTL]) lcr_n = bus_wdata;
    if (wr_hit[OFS_MCTL]) mcr_n = bus_wdata[MCTL_W-1:0];
    if (wr_hit[OFS_SCR])  scr_n = bus_wdata;

    if (wr_hit[OFS_IEN]) begin
      ier_n = bus_wdata[IEN_W-1:0];
      if (thre_q) thr_pend_n = 1'b1;
    end

    if (wr_hit[OFS_DATA]) begin
      txb_n      = bus_wdata;
      thr_pend_n = 1'b1;
      thre_n     = 1'b1;
      temt_n     = 1'b1;
    end

    if (rd_hit[OFS_DATA]) begin
      dr_n = 1'b0;
      bi_n = 1'b0;
    end

    if (rd_hit[OFS_IID] && (code == ID_TXE)) thr_pend_n = 1'b0;

    // receive side; applied after the read clear so a same-cycle break wins
    if (rx_break) begin
      rbr_n = '0;
      dr_n  = 1'b1;
      bi_n  = 1'b1;
    end else if (rx_valid && !dr_q) begin
      rbr_n = rx_byte;
      dr_n  = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q      <= '0;
      div_q      <= '0;
      ier_q      <= '0;
      lcr_q      <= '0;
      mcr_q      <= '0;
      scr_q      <= '0;
      txb_q      <= '0;
      txs_q      <= 1'b0;
      dr_q       <= 1'b0;
      bi_q       <= 1'b0;
      thre_q     <= 1'b1;
      temt_q     <= 1'b1;
      thr_pend_q <= 1'b0;
    end else begin
      rbr_q      <= rbr_n;
      div_q      <= div_n;
      ier_q      <= ier_n;
      lcr_q      <= lcr_n;
      mcr_q      <= mcr_n;
      scr_q      <= scr_n;
      txb_q      <= txb_n;
      txs_q      <= txs_n;
      dr_q       <= dr_n;
      bi_q       <= bi_n;
      thre_q     <= thre_n;
      temt_q     <= temt_n;
      thr_pend_q <= thr_pend_n;
    end
  end

  assign rx_ready  = ~dr_q;
  assign tx_byte   = txb_q;
  assign tx_strobe = txs_q;
  assign irq       = req;
  assign irq_code  = code;
  assign line_ctl  = lcr_q;
  assign divisor   = div_q;
  assign modem_ctl = mcr_q;
endmodule

// File: rtl/uart_regbank_checker.sv
module uart_regbank_checker
  import uart_rb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [OFS_W-1:0]  bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              rx_break,
  input logic              rx_ready,
  input logic [REG_W-1:0]  tx_byte,
  input logic              tx_strobe,
  input logic              irq,
  input logic [REG_W-1:0]  irq_code,
  input logic [REG_W-1:0]  line_ctl,
  input logic              dr_q,
  input logic              thr_pend_q,
  input logic [IEN_W-1:0]  ier_q,
  input logic              thre_q,
  input logic              temt_q,
  input logic [REG_W-1:0]  rbr_q
);
  logic data_wr;
  assign data_wr = bus_sel && bus_wr && (bus_addr == OFS_DATA) && !line_ctl[LC_DIVSEL];

  p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code == ID_NONE) || (irq_code == ID_TXE) || (irq_code == ID_RXD));

  p_irq_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_code != ID_NONE));

  p_rx_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && ier_q[0]) |-> (irq_code == ID_RXD));

  p_iid_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFS_IID && irq_code == ID_TXE) |=> !thr_pend_q);

  p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_IEN && !line_ctl[LC_DIVSEL] && thre_q)
      |=> thr_pend_q);

  p_tx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (tx_strobe && tx_byte == $past(bus_wdata) && thr_pend_q));

  p_tx_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(data_wr));

  p_status_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thre_q && temt_q);

  p_rdy_inv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready == !dr_q);

  p_rx_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !rx_break) |=> $stable(rbr_q));

  p_break_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> (!rx_ready && rbr_q == '0));
endmodule

bind uart_regbank uart_regbank_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .rx_break   (rx_break),
  .rx_ready   (rx_ready),
  .tx_byte    (tx_byte),
  .tx_strobe  (tx_strobe),
  .irq        (irq),
  .irq_code   (irq_code),
  .line_ctl   (line_ctl),
  .dr_q       (dr_q),
  .thr_pend_q (thr_pend_q),
  .ier_q      (ier_q),
  .thre_q     (thre_q),
  .temt_q     (temt_q),
  .rbr_q      (rbr_q)
);

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_break = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_byte;
  logic        tx_strobe;
  logic        irq;
  logic [7:0]  irq_code;
  logic [7:0]  line_ctl;
  logic [15:0] divisor;
  logic [4:0]  modem_ctl;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  uart_regbank u_uart_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_break(rx_break),
    .rx_ready(rx_ready), .tx_byte(tx_byte), .tx_strobe(tx_strobe),
    .irq(irq), .irq_code(irq_code), .line_ctl(line_ctl),
    .divisor(divisor), .modem_ctl(modem_ctl)
  );

  // vector: {is_read, offset[2:0], wdata[7:0], expected[7:0]}
  localparam int NV = 18;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd3, 8'h83, 8'h00},   // R2 enter divisor mode
    {1'b0, 3'd0, 8'h34, 8'h00},   // R2 divisor low
    {1'b0, 3'd1, 8'h12, 8'h00},   // R2 divisor high
    {1'b1, 3'd0, 8'h00, 8'h34},   // R2
    {1'b1, 3'd1, 8'h00, 8'h12},   // R2
    {1'b1, 3'd3, 8'h00, 8'h83},   // R1 line control readback
    {1'b0, 3'd3, 8'h03, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h00},   // R2 enables untouched by divisor writes
    {1'b1, 3'd0, 8'h00, 8'h00},   // R2 receive register untouched
    {1'b0, 3'd1, 8'hFC, 8'h00},   // R3 enable write, low nibble 0xC
    {1'b1, 3'd1, 8'h00, 8'h0C},   // R3
    {1'b0, 3'd4, 8'hEB, 8'h00},   // R3 modem control
    {1'b1, 3'd4, 8'h00, 8'h0B},   // R3
    {1'b0, 3'd4, 8'h00, 8'h00},
    {1'b0, 3'd7, 8'hA5, 8'h00},   // R1 scratch
    {1'b1, 3'd7, 8'h00, 8'hA5},   // R1
    {1'b1, 3'd5, 8'h00, 8'h60},   // R1 line status
    {1'b1, 3'd6, 8'h00, 8'hB0}    // R1 modem status
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_read(a, d);
    check(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic rx_push(input logic [7:0] b, input logic brk);
    rx_byte = b; rx_valid = ~brk; rx_break = brk;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset contents
    check("R10 irq", {15'd0, irq}, 16'd0);
    check("R10 rx_ready", {15'd0, rx_ready}, 16'd1);
    read_check("R10 data", 3'd0, 8'h00);
    read_check("R10 ien", 3'd1, 8'h00);
    read_check("R10 iid", 3'd2, 8'h01);
    read_check("R10 lctl", 3'd3, 8'h00);
    read_check("R10 mctl", 3'd4, 8'h00);
    read_check("R10 lstat", 3'd5, 8'h60);
    read_check("R10 mstat", 3'd6, 8'hB0);
    read_check("R10 scr", 3'd7, 8'h00);

    // table walk (R1 R2 R3)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) read_check("R1/R2/R3 vector", VEC[i][18:16], VEC[i][7:0]);
      else            bus_write(VEC[i][18:16], VEC[i][15:8]);
      if (i == 1) check("R2 no tx in divisor mode", {15'd0, tx_strobe}, 16'd0);
    end
    check("R2 divisor port", divisor, 16'h1234);
    check("R3 modem_ctl port", {11'd0, modem_ctl}, 16'd0);

    // enables 0xC: no source enabled, even though pending was armed (R6)
    check("R4 no enabled source", {8'h00, irq_code}, 16'h0001);
    bus_write(3'd1, 8'h02);                       // R6 re-arm and enable tx source
    check("R6 irq after enable write", {15'd0, irq}, 16'd1);
    read_check("R5 iid reports tx", 3'd2, 8'h02);
    check("R5 pending cleared", {15'd0, irq}, 16'd0);
    read_check("R5 iid now none", 3'd2, 8'h01);

    // R4 priority: rx data over tx
    bus_write(3'd1, 8'h03);
    rx_push(8'h5A, 1'b0);
    check("R11 rx_ready low", {15'd0, rx_ready}, 16'd0);
    read_check("R4 rx wins", 3'd2, 8'h04);
    read_check("R5 non-tx read keeps flag", 3'd2, 8'h04);
    read_check("R8 lstat data ready", 3'd5, 8'h61);
    rx_push(8'h77, 1'b0);                         // R11 dropped
    read_check("R8/R11 data read", 3'd0, 8'h5A);
    read_check("R8 lstat cleared", 3'd5, 8'h60);
    check("R11 rx_ready high", {15'd0, rx_ready}, 16'd1);
    read_check("R4 tx after rx gone", 3'd2, 8'h02);
    check("R4 irq low", {15'd0, irq}, 16'd0);

    // R7 transmit
    bus_write(3'd0, 8'hC3);
    check("R7 strobe", {15'd0, tx_strobe}, 16'd1);
    check("R7 byte", {8'h00, tx_byte}, 16'h00C3);
    @(posedge clk); @(negedge clk);
    check("R7 strobe single", {15'd0, tx_strobe}, 16'd0);
    read_check("R7 pending set", 3'd2, 8'h02);
    read_check("R7 lstat", 3'd5, 8'h60);

    // R12 break
    rx_push(8'hEE, 1'b1);
    read_check("R12 lstat", 3'd5, 8'h71);
    read_check("R12 data zero", 3'd0, 8'h00);
    read_check("R12 lstat after read", 3'd5, 8'h60);

    // R9 loopback
    bus_write(3'd4, 8'h1D);
    read_check("R9 loop 1D", 3'd6, 8'hE0);
    bus_write(3'd4, 8'h12);
    read_check("R9 loop 12", 3'd6, 8'h10);
    bus_write(3'd4, 8'h0F);
    read_check("R9 loop off", 3'd6, 8'hB0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule